// File: doc/BRIEF.md
# Shadow-Checked Pin Output Routing Registers

This block keeps one 5-bit output-function selector for each remappable pin and uses it to choose which on-chip peripheral output drives that pin. A selector can route the pin to its general-purpose port latch, to the serial transmit or request-to-send line, to the SPI data, clock or select output, or to either of two compare outputs. Bus writes into the selectors take effect only while an external permit input is high. The lock sequencing that drives that permit input is outside this block.

Every selector has a hidden shadow copy. A permitted write loads the live selector and its shadow on the same clock edge. A comparator checks all live selectors against their shadows on every cycle. If any pair disagrees, for example because a storage cell was upset, the block raises a sticky configuration-mismatch reset request. The request stays high until the block itself is reset.

A fault-injection input for test flips one bit of a chosen live selector and leaves its shadow untouched. This lets the detection path be exercised.

Top module: `pin_remap_top`

## Requirements
- R1: After reset, every selector holds 00000, so each pin_o[p] follows port_latch_i[p], and mismatch_rst_o is low.
- R2: After a permitted write, code 00000 routes the pin to its port latch, 00011 to uart_tx_i and 00100 to uart_rts_i.
- R3: After a permitted write, code 00111 routes the pin to spi_sdo_i, 01000 to spi_sck_i, 01001 to spi_ss_i, 10010 to oc1_i and 10011 to oc2_i.
- R4: Every code not listed in R2 or R3 drives the pin from its port latch.
- R5: A write presented while wr_permit_i is low leaves the addressed selector unchanged, which is observable as unchanged routing on pin_o.
- R6: Permitted writes alone never raise mismatch_rst_o.
- R7: An injection with inj_bit_i below 5 flips that bit of the addressed live selector at the clock edge, and routing follows the corrupted value at once. mismatch_rst_o rises on the following clock edge and is still low before that edge.
- R8: Once raised, mismatch_rst_o stays high, including after a permitted rewrite of the corrupted selector.
- R9: Asserting rst_ni clears mismatch_rst_o and returns all selectors and shadows to 00000.
- R10: A write to one pin's selector does not alter the routing of any other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Selector write strobe |
| wr_permit_i | input | 1 | Write permission from the lock logic |
| wr_addr_i | input | ADDR_W | Pin index to write |
| wr_data_i | input | 5 | Selector code to write |
| inj_en_i | input | 1 | Test fault-injection strobe |
| inj_addr_i | input | ADDR_W | Pin whose live selector is corrupted |
| inj_bit_i | input | BIT_W | Bit to flip; values of 5 and above flip nothing |
| port_latch_i | input | NUM_PINS | Default port latch value for each pin |
| uart_tx_i | input | 1 | Serial transmit source |
| uart_rts_i | input | 1 | Serial request-to-send source |
| spi_sdo_i | input | 1 | SPI data output source |
| spi_sck_i | input | 1 | SPI clock output source |
| spi_ss_i | input | 1 | SPI select output source |
| oc1_i | input | 1 | Compare output 1 source |
| oc2_i | input | 1 | Compare output 2 source |
| pin_o | output | NUM_PINS | Routed pin outputs |
| mismatch_rst_o | output | 1 | Sticky configuration-mismatch reset request |

## Verification
Routing is exercised with eight one-hot source patterns. In each pattern exactly one of the port latch and the seven peripheral lines is high, so a pin that picks the wrong source reads a wrong value for at least one pattern. All 32 codes are swept through one pin under these patterns, which separates the eight assigned codes from one another and from the unassigned codes that fall back to the latch. Distinct codes are then loaded on all pins at once to show that routing stays independent from pin to pin. Injection is applied both to a code whose flipped value stays unassigned, where routing is unchanged but the alarm must still fire, and to a code whose flipped value selects another peripheral. A blocked write is also tried; it must change neither routing nor the alarm.

// File: rtl/pin_remap_pkg.sv
package pin_remap_pkg;
  localparam int unsigned SEL_W = 5;
  typedef logic [SEL_W-1:0] sel_t;

  localparam sel_t SEL_LATCH = 5'b00000;
  localparam sel_t SEL_U_TX  = 5'b00011;
  localparam sel_t SEL_U_RTS = 5'b00100;
  localparam sel_t SEL_SDO   = 5'b00111;
  localparam sel_t SEL_SCK   = 5'b01000;
  localparam sel_t SEL_SS    = 5'b01001;
  localparam sel_t SEL_OC1   = 5'b10010;
  localparam sel_t SEL_OC2   = 5'b10011;

  typedef struct packed {
    logic oc2;
    logic oc1;
    logic ss;
    logic sck;
    logic sdo;
    logic rts;
    logic tx;
  } periph_t;
endpackage

// File: rtl/remap_sel_bank.sv
module remap_sel_bank
  import pin_remap_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  parameter int unsigned BIT_W    = $clog2(SEL_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_permit_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  sel_t              wr_data_i,
  input  logic              inj_en_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  logic [BIT_W-1:0]  inj_bit_i,
  output sel_t              live_o   [NUM_PINS],
  output sel_t              shadow_o [NUM_PINS]
);
  // out-of-range bit index shifts the one out and yields an empty mask
  sel_t flip_mask;
  assign flip_mask = sel_t'(1) << inj_bit_i;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic wr_hit, inj_hit;
    sel_t live_q, shadow_q, mask;

    assign wr_hit  = wr_en_i && wr_permit_i && (wr_addr_i == ADDR_W'(p));
    assign inj_hit = inj_en_i && (inj_addr_i == ADDR_W'(p));
    assign mask    = inj_hit ? flip_mask : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_q   <= SEL_LATCH;
        shadow_q <= SEL_LATCH;
      end else if (wr_hit) begin
        live_q   <= wr_data_i ^ mask;
        shadow_q <= wr_data_i;
      end else begin
        live_q   <= live_q ^ mask;
      end
    end

    assign live_o[p]   = live_q;
    assign shadow_o[p] = shadow_q;
  end
endmodule

// File: rtl/remap_cmp.sv
module remap_cmp
  import pin_remap_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  sel_t live_i   [NUM_PINS],
  input  sel_t shadow_i [NUM_PINS],
  output logic mismatch_o
);
  logic [NUM_PINS-1:0] diff;
  logic                flag_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cmp
    assign diff[p] = (live_i[p] != shadow_i[p]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (|diff)  flag_q <= 1'b1;
  end

  assign mismatch_o = flag_q;
endmodule

// File: rtl/remap_out_mux.sv
module remap_out_mux
  import pin_remap_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  sel_t                sel_i [NUM_PINS],
  input  logic [NUM_PINS-1:0] latch_i,
  input  periph_t             src_i,
  output logic [NUM_PINS-1:0] pin_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_mux
    always_comb begin
      unique case (sel_i[p])
        SEL_U_TX:  pin_o[p] = src_i.tx;
        SEL_U_RTS: pin_o[p] = src_i.rts;
        SEL_SDO:   pin_o[p] = src_i.sdo;
        SEL_SCK:   pin_o[p] = src_i.sck;
        SEL_SS:    pin_o[p] = src_i.ss;
        SEL_OC1:   pin_o[p] = src_i.oc1;
        SEL_OC2:   pin_o[p] = src_i.oc2;
        default:   pin_o[p] = latch_i[p];
      endcase
    end
  end
endmodule

// File: rtl/pin_remap_top.sv
module pin_remap_top
  import pin_remap_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  parameter int unsigned BIT_W    = $clog2(SEL_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_permit_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [SEL_W-1:0]    wr_data_i,
  input  logic                inj_en_i,
  input  logic [ADDR_W-1:0]   inj_addr_i,
  input  logic [BIT_W-1:0]    inj_bit_i,
  input  logic [NUM_PINS-1:0] port_latch_i,
  input  logic                uart_tx_i,
  input  logic                uart_rts_i,
  input  logic                spi_sdo_i,
  input  logic                spi_sck_i,
  input  logic                spi_ss_i,
  input  logic                oc1_i,
  input  logic                oc2_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic                mismatch_rst_o
);
  sel_t    live   [NUM_PINS];
  sel_t    shadow [NUM_PINS];
  periph_t src;
  logic [NUM_PINS*SEL_W-1:0] live_flat;

  assign src = '{oc2: oc2_i, oc1: oc1_i, ss: spi_ss_i, sck: spi_sck_i,
                 sdo: spi_sdo_i, rts: uart_rts_i, tx: uart_tx_i};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_flat
    assign live_flat[p*SEL_W +: SEL_W] = live[p];
  end

  remap_sel_bank #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .BIT_W(BIT_W)
  ) i_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_permit_i (wr_permit_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .inj_en_i    (inj_en_i),
    .inj_addr_i  (inj_addr_i),
    .inj_bit_i   (inj_bit_i),
    .live_o      (live),
    .shadow_o    (shadow)
  );

  remap_cmp #(.NUM_PINS(NUM_PINS)) i_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .live_i     (live),
    .shadow_i   (shadow),
    .mismatch_o (mismatch_rst_o)
  );

  remap_out_mux #(.NUM_PINS(NUM_PINS)) i_mux (
    .sel_i   (live),
    .latch_i (port_latch_i),
    .src_i   (src),
    .pin_o   (pin_o)
  );
endmodule

// File: rtl/pin_remap_chk.sv
module pin_remap_chk #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned SEL_W    = 5,
  parameter int unsigned BIT_W    = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      wr_en_i,
  input logic                      wr_permit_i,
  input logic                      inj_en_i,
  input logic [BIT_W-1:0]          inj_bit_i,
  input logic [NUM_PINS*SEL_W-1:0] live_flat,
  input logic                      mismatch_rst_o
);
  logic inj_valid, inj_seen_q;
  assign inj_valid = inj_en_i && (32'(inj_bit_i) < SEL_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        inj_seen_q <= 1'b0;
    else if (inj_valid) inj_seen_q <= 1'b1;
  end

  a_r5_blocked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_en_i && wr_permit_i) && !inj_en_i) |=> $stable(live_flat));

  a_r6_no_false_alarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inj_seen_q |-> !mismatch_rst_o);

  a_r7_detect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_valid |-> ##2 mismatch_rst_o);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_rst_o |=> mismatch_rst_o);
endmodule

bind pin_remap_top pin_remap_chk #(
  .NUM_PINS(NUM_PINS), .SEL_W(pin_remap_pkg::SEL_W), .BIT_W(BIT_W)
) i_pin_remap_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .wr_permit_i    (wr_permit_i),
  .inj_en_i       (inj_en_i),
  .inj_bit_i      (inj_bit_i),
  .live_flat      (live_flat),
  .mismatch_rst_o (mismatch_rst_o)
);

// File: tb/test_pin_remap_top.sv
module test_pin_remap_top;
  localparam int unsigned NP = 8;
  localparam int unsigned AW = 3;
  localparam int unsigned BW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, wr_permit = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [4:0]    wr_data = '0;
  logic          inj_en = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [BW-1:0] inj_bit = '0;
  logic [NP-1:0] latch = '0;
  logic          tx = 0, rts = 0, sdo = 0, sck = 0, ss = 0, oc1 = 0, oc2 = 0;
  logic [NP-1:0] pin;
  logic          mism;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pin_remap_top #(.NUM_PINS(NP)) i_pin_remap_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_permit_i(wr_permit),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .inj_en_i(inj_en),
    .inj_addr_i(inj_addr), .inj_bit_i(inj_bit), .port_latch_i(latch),
    .uart_tx_i(tx), .uart_rts_i(rts), .spi_sdo_i(sdo), .spi_sck_i(sck),
    .spi_ss_i(ss), .oc1_i(oc1), .oc2_i(oc2), .pin_o(pin), .mismatch_rst_o(mism)
  );

  // source index: 0 latch, 1 tx, 2 rts, 3 sdo, 4 sck, 5 ss, 6 oc1, 7 oc2
  function automatic int src_of(input logic [4:0] code);
    case (code)
      5'b00011: return 1;
      5'b00100: return 2;
      5'b00111: return 3;
      5'b01000: return 4;
      5'b01001: return 5;
      5'b10010: return 6;
      5'b10011: return 7;
      default:  return 0;
    endcase
  endfunction

  function automatic string req_of(input logic [4:0] code);
    int s = src_of(code);
    if (s == 0 && code != 5'b00000) return "R4";
    if (s <= 2) return "R2";
    return "R3";
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive_src(input int k);
    latch = (k == 0) ? '1 : '0;
    tx = (k == 1); rts = (k == 2); sdo = (k == 3); sck = (k == 4);
    ss = (k == 5); oc1 = (k == 6); oc2 = (k == 7);
  endtask

  // checks pin p against code over all one-hot source patterns
  task automatic chk_route(input string req, input int p, input logic [4:0] code);
    for (int k = 0; k < 8; k++) begin
      drive_src(k);
      #1;
      chk(req, pin[p], src_of(code) == k);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int a, input logic [4:0] d, input logic permit);
    @(negedge clk);
    wr_en = 1'b1; wr_permit = permit; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_permit = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1", mism, 1'b0);
    for (int p = 0; p < NP; p++) chk_route("R1", p, 5'b00000);
  endtask

  task automatic t_all_codes();
    for (int c = 0; c < 32; c++) begin
      wr(2, 5'(c), 1'b1);
      chk_route(req_of(5'(c)), 2, 5'(c));
      chk("R6", mism, 1'b0);
    end
  endtask

  task automatic t_blocked_write();
    wr(1, 5'b00011, 1'b1);
    wr(1, 5'b00111, 1'b0);
    chk_route("R5", 1, 5'b00011);
    chk("R5", mism, 1'b0);
  endtask

  task automatic t_independent();
    logic [4:0] codes [NP];
    codes = '{5'b00011, 5'b00100, 5'b00111, 5'b01000,
              5'b01001, 5'b10010, 5'b10011, 5'b00000};
    for (int p = 0; p < NP; p++) wr(p, codes[p], 1'b1);
    for (int p = 0; p < NP; p++) chk_route("R10", p, codes[p]);
    chk("R6", mism, 1'b0);
  endtask

  task automatic inject(input int a, input int b);
    @(negedge clk);
    inj_en = 1'b1; inj_addr = AW'(a); inj_bit = BW'(b);
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic t_inject_quiet();
    do_reset();
    inject(4, 0);                      // 00000 -> 00001, still latch routed
    chk("R7", mism, 1'b0);
    chk_route("R7", 4, 5'b00001);
    @(negedge clk);
    chk("R7", mism, 1'b1);
    wr(4, 5'b00000, 1'b1);
    repeat (3) @(negedge clk);
    chk("R8", mism, 1'b1);
    do_reset();
    chk("R9", mism, 1'b0);
    chk_route("R9", 4, 5'b00000);
  endtask

  task automatic t_inject_reroute();
    do_reset();
    wr(5, 5'b00011, 1'b1);
    inject(5, 2);                      // 00011 -> 00111
    chk_route("R7", 5, 5'b00111);
    chk_route("R7", 6, 5'b00000);
    @(negedge clk);
    chk("R7", mism, 1'b1);
    do_reset();
    inject(3, 6);                      // bit beyond width flips nothing
    repeat (2) @(negedge clk);
    chk("R7", mism, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_all_codes();
    t_blocked_write();
    t_independent();
    t_inject_quiet();
    t_inject_reroute();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule